// File: doc/BRIEF.md
# Programmable Power-Up Delay Timer

This block keeps the rest of the chip in reset after power-on until a chosen delay has run out. It runs from a free-running low-speed reference clock and takes the raw, active-low power-on-reset signal. It brings that signal into its own clock domain and then counts whole milliseconds before it raises a reset-release level. The release level stays high until the next power-on reset.

A 3-bit code picks the delay. Code zero turns the delay off. Each non-zero code `n` waits `2^n` ms, so the seven steps run from 2 ms to 128 ms and each step doubles the one before it. The block reads the code once, on the first cycle after the synchronised power-on reset goes inactive, and later changes to the code have no effect.

A build parameter selects a fixed variant. That variant ignores the code and always waits 64 ms. A second parameter sets how many reference-clock cycles make up one millisecond. A busy output is high while the count runs.

Top module: `pwrup_delay_timer`

## Requirements
- R1: While the synchronised power-on reset is asserted, `rel_o` and `busy_o` are both low.
- R2: With code 0 in the programmable variant, `rel_o` goes high on the 3rd rising clock edge after `por_raw_n` rises (two synchroniser stages plus one sequencing edge).
- R3: With code n in 1..7 in the programmable variant, `rel_o` goes high on rising edge 3 + 2^n × CYC_PER_MS after `por_raw_n` rises. The delays are 2, 4, 8, 16, 32, 64 and 128 ms.
- R4: `busy_o` is high from the 3rd edge after `por_raw_n` rises until the edge that raises `rel_o`, and low otherwise. It is never high together with `rel_o`. With code 0 it never goes high.
- R5: The code is sampled only on the 3rd edge after `por_raw_n` rises. A change to `cfg_code` while the count runs does not change when `rel_o` rises.
- R6: Once high, `rel_o` stays high without glitches for as long as `por_raw_n` stays high, whatever `cfg_code` does.
- R7: When `por_raw_n` falls, `rel_o` is still high after the 2nd rising edge and low after the 3rd. The next power-up samples the code afresh.
- R8: With FIXED_INTERVAL = 1, `rel_o` goes high on edge 3 + 64 × CYC_PER_MS after `por_raw_n` rises, for every code including 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running low-speed reference clock |
| por_raw_n | input | 1 | Raw power-on reset, active low, asynchronous to clk_ref |
| cfg_code | input | 3 | Delay select: 0 = no delay, n = 2^n ms |
| rel_o | output | 1 | Reset release, registered level, high when the delay is over |
| busy_o | output | 1 | High while the millisecond count is in progress |

## Verification
The assertions check on every cycle that the release level is sticky, that busy and release are never high together, that the latched limit stays frozen while counting, that the millisecond count never passes its limit, and that millisecond ticks never come on two edges in a row. Only the bench scenarios can show the exact number of cycles from power-on reset to release for each code and for the fixed variant. The same holds for the 3-cycle loss of release after power-on reset returns, and for the fact that a code change during the count is ignored, which the bench measures at the ports.

// File: rtl/pud_pkg.sv
// Package: shared types for the power-up delay timer.
// Assumes: none; holds only the sequencer state encoding.
package pud_pkg;

    // Sequencer state: waiting for reset to clear, counting, or released.
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pud_por_sync.sv
// Module: pud_por_sync
// Brings the raw active-low power-on reset into the reference clock domain
// through a chain of SYNC_STAGES flops.
// Assumes: por_raw_n may change at any time. The flops carry no reset because
// they are the source of the reset for everything downstream.
module pud_por_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_raw_n,
    output logic por_sync_n
);

    logic [SYNC_STAGES-1:0] chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            // Purpose: single-stage capture of the raw reset.
            always_ff @(posedge clk) begin
                chain_q <= por_raw_n;
            end
        end else begin : g_multi
            // Purpose: shift the raw reset through the synchroniser chain.
            always_ff @(posedge clk) begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], por_raw_n};
            end
        end
    endgenerate

    assign por_sync_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/pud_interval_decode.sv
// Module: pud_interval_decode
// Turns the delay code into a terminal millisecond count (target - 1) and a
// flag for "no delay". With USE_FIXED the code is ignored and FIXED_MS is used.
// Assumes: MS_W is wide enough to hold the largest terminal count.
module pud_interval_decode #(
    parameter int CODE_W    = 3,
    parameter int MS_W      = 7,
    parameter bit USE_FIXED = 1'b0,
    parameter int FIXED_MS  = 64
) (
    input  logic [CODE_W-1:0] code,
    output logic [MS_W-1:0]   limit,
    output logic              no_delay
);

    generate
        if (USE_FIXED) begin : g_fixed
            logic unused_code;
            // Purpose: the fixed build ignores the code.
            assign unused_code = ^code;
            assign limit       = MS_W'(FIXED_MS - 1);
            assign no_delay    = 1'b0;
        end else begin : g_prog
            logic [MS_W:0] span_ms;
            // Purpose: code n gives 2^n ms; code 0 disables the wait.
            always_comb begin
                span_ms  = (MS_W + 1)'(1) << code;
                limit    = MS_W'(span_ms - (MS_W + 1)'(1));
                no_delay = (code == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/pud_ms_prescaler.sv
// Module: pud_ms_prescaler
// Divides the reference clock into one-cycle millisecond ticks while run is
// high. The tick comes on the CYC_PER_MS-th edge of each period.
// Assumes: synchronous active-low reset; run drops to restart the phase.
module pud_ms_prescaler #(
    parameter int CYC_PER_MS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    // Purpose: advance the phase counter while running, wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    generate
        if (CYC_PER_MS > 1) begin : g_spacing_chk
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/pud_sequencer.sv
// Module: pud_sequencer
// Latches the terminal count on the first cycle out of reset, counts
// millisecond ticks, and raises a registered, sticky release level.
// Assumes: synchronous active-low reset from the synchroniser; limit and
// no_delay are valid combinationally from the current code.
module pud_sequencer
    import pud_pkg::*;
#(
    parameter int MS_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MS_W-1:0] limit_in,
    input  logic            no_delay_in,
    input  logic            ms_tick,
    output logic            busy,
    output logic            release_lvl
);

    seq_state_t      state_q;
    logic [MS_W-1:0] limit_q;
    logic [MS_W-1:0] ms_cnt_q;
    logic            busy_q;
    logic            rel_q;
    logic            noDelay_unused_guard;

    assign noDelay_unused_guard = no_delay_in;

    // Purpose: state, latched limit, millisecond count and output flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_HOLD;
            limit_q  <= '0;
            ms_cnt_q <= '0;
            busy_q   <= 1'b0;
            rel_q    <= 1'b0;
        end else begin
            case (state_q)
                SEQ_HOLD: begin
                    limit_q  <= limit_in;
                    ms_cnt_q <= '0;
                    if (noDelay_unused_guard) begin
                        state_q <= SEQ_DONE;
                        rel_q   <= 1'b1;
                    end else begin
                        state_q <= SEQ_COUNT;
                        busy_q  <= 1'b1;
                    end
                end
                SEQ_COUNT: begin
                    if (ms_tick) begin
                        if (ms_cnt_q == limit_q) begin
                            state_q <= SEQ_DONE;
                            busy_q  <= 1'b0;
                            rel_q   <= 1'b1;
                        end else begin
                            ms_cnt_q <= ms_cnt_q + MS_W'(1);
                        end
                    end
                end
                SEQ_DONE: begin
                    rel_q <= 1'b1;
                end
                default: begin
                    state_q <= SEQ_HOLD;
                    busy_q  <= 1'b0;
                    rel_q   <= 1'b0;
                end
            endcase
        end
    end

    assign busy        = busy_q;
    assign release_lvl = rel_q;

    AST_REL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> rel_q); // R6
    AST_BUSY_REL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && rel_q)); // R4
    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(limit_q)); // R5
    AST_MS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (ms_cnt_q <= limit_q)); // R3
    AST_REL_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ms_tick) |=> !rel_q); // R3

endmodule

// File: rtl/pwrup_delay_timer.sv
// Module: pwrup_delay_timer (top)
// Holds the reset-release low after power-on until a code-selected delay in
// milliseconds has run out. FIXED_INTERVAL builds a variant that always
// waits 64 ms. CYC_PER_MS sets reference-clock cycles per millisecond.
// Assumes: clk_ref runs freely; por_raw_n is asynchronous and active low.
module pwrup_delay_timer #(
    parameter int CODE_W         = 3,
    parameter int CYC_PER_MS     = 33,
    parameter bit FIXED_INTERVAL = 1'b0,
    parameter int FIXED_MS       = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk_ref,
    input  logic              por_raw_n,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              rel_o,
    output logic              busy_o
);

    localparam int PROG_MAX_MS = 1 << ((1 << CODE_W) - 1);
    localparam int MAX_MS      = FIXED_INTERVAL ? FIXED_MS : PROG_MAX_MS;
    localparam int MS_W        = (MAX_MS > 1) ? $clog2(MAX_MS) : 1;

    logic            por_s_n;
    logic [MS_W-1:0] limit_w;
    logic            no_delay_w;
    logic            tick_w;
    logic            busy_w;
    logic            rel_w;

    pud_por_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk_ref),
        .por_raw_n  (por_raw_n),
        .por_sync_n (por_s_n)
    );

    pud_interval_decode #(
        .CODE_W    (CODE_W),
        .MS_W      (MS_W),
        .USE_FIXED (FIXED_INTERVAL),
        .FIXED_MS  (FIXED_MS)
    ) u_decode (
        .code     (cfg_code),
        .limit    (limit_w),
        .no_delay (no_delay_w)
    );

    pud_ms_prescaler #(
        .CYC_PER_MS (CYC_PER_MS)
    ) u_presc (
        .clk   (clk_ref),
        .rst_n (por_s_n),
        .run   (busy_w),
        .tick  (tick_w)
    );

    pud_sequencer #(
        .MS_W (MS_W)
    ) u_seq (
        .clk         (clk_ref),
        .rst_n       (por_s_n),
        .limit_in    (limit_w),
        .no_delay_in (no_delay_w),
        .ms_tick     (tick_w),
        .busy        (busy_w),
        .release_lvl (rel_w)
    );

    assign rel_o  = rel_w;
    assign busy_o = busy_w;

    AST_BUSY_NO_TICK_AFTER_REL: assert property (@(posedge clk_ref) disable iff (!por_s_n)
        rel_o |-> !tick_w); // R4

endmodule

// File: tb/test_pwrup_delay_timer.sv
module test_pwrup_delay_timer;

    localparam int CPM = 4;

    logic       clk = 1'b0;
    logic       por_raw_n = 1'b0;
    logic [2:0] cfg_code = 3'd0;
    logic       rel_p, busy_p, rel_f, busy_f;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwrup_delay_timer #(.CYC_PER_MS(CPM), .FIXED_INTERVAL(1'b0)) i_pwrup_delay_timer (
        .clk_ref(clk), .por_raw_n(por_raw_n), .cfg_code(cfg_code),
        .rel_o(rel_p), .busy_o(busy_p));

    pwrup_delay_timer #(.CYC_PER_MS(CPM), .FIXED_INTERVAL(1'b1)) i_pwrup_delay_timer_fixed (
        .clk_ref(clk), .por_raw_n(por_raw_n), .cfg_code(cfg_code),
        .rel_o(rel_f), .busy_o(busy_f));

    function automatic int exp_edges(input int code, input bit fixed);
        int ms;
        if (fixed) ms = 64;
        else if (code == 0) ms = 0;
        else ms = 1 << code;
        return 3 + ms * CPM;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_neg();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Power cycle, then measure the release edge for a code, optionally
    // changing the code mid-count (at negedge change_at).
    task automatic run_seq(input int code, input int change_at, input int new_code);
        int seen_p, seen_f, busy_err, ep, ef;
        if (rel_p) begin
            por_raw_n = 1'b0;
            tick_neg();
            tick_neg();
            check(rel_p == 1'b1, "R7 release held 2 edges", rel_p, 1);
            tick_neg();
            check(rel_p == 1'b0, "R7 release drops on edge 3", rel_p, 0);
        end
        por_raw_n = 1'b0;
        repeat (4) tick_neg();
        check(!rel_p && !busy_p && !rel_f && !busy_f, "R1 outputs low in reset",
              {rel_p, busy_p, rel_f, busy_f}, 0);
        cfg_code = 3'(code);
        por_raw_n = 1'b1;
        ep = exp_edges(code, 1'b0);
        ef = exp_edges(code, 1'b1);
        seen_p = 0; seen_f = 0; busy_err = 0;
        for (int n = 1; n <= 600; n++) begin
            tick_neg();
            if (n == change_at) cfg_code = 3'(new_code);
            if (rel_p && seen_p == 0) seen_p = n;
            if (rel_f && seen_f == 0) seen_f = n;
            if (busy_p != (code != 0 && n >= 3 && n < ep)) busy_err++;
            if (busy_p && rel_p) busy_err++;
            if (seen_p != 0 && seen_f != 0 && n > ef && n > ep) break;
        end
        if (code == 0)
            check(seen_p == ep, "R2 code 0 release edge", seen_p, ep);
        else if (change_at != 0)
            check(seen_p == ep, "R5 code change ignored", seen_p, ep);
        else
            check(seen_p == ep, "R3 release edge for code", seen_p, ep);
        check(seen_f == ef, "R8 fixed 64 ms release edge", seen_f, ef);
        check(busy_err == 0, "R4 busy window", busy_err, 0);
    endtask

    initial begin
        int c, k;
        void'($urandom(32'd20240611));
        repeat (3) tick_neg();
        // Directed: every code in turn.
        for (int i = 0; i < 8; i++) run_seq(i, 0, 0);
        // Directed: code changes mid-count, both ways.
        run_seq(2, 10, 7);
        run_seq(7, 40, 1);
        // R6: code changes after release leave release high.
        k = 0;
        for (int i = 0; i < 20; i++) begin
            cfg_code = 3'(i);
            tick_neg();
            if (!rel_p || !rel_f) k++;
        end
        check(k == 0, "R6 release sticky", k, 0);
        // Random codes, some with a mid-count change.
        for (int i = 0; i < 6; i++) begin
            c = int'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1 && c != 0)
                run_seq(c, int'($urandom_range(4, 8)), int'($urandom_range(0, 7)));
            else
                run_seq(c, 0, 0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule